// File: doc/BRIEF.md
# Multi-Width Rotate-Left Unit with Carry and Overflow Update

This block is one pipelined execution stage that rotates an operand to the left. The operand can be 8, 16, 32 or 64 bits wide. It takes a 64-bit operand bus, a size code, a raw 8-bit shift count and the incoming carry and overflow flags. One clock later it returns the rotated value and the new flags, together with a strobe that says whether the flags are to be written back. Only the low bits of the chosen width take part in the rotation. Every bit above that width reads as zero on the output.

The count is first masked: 5 bits are kept for the three narrower widths and 6 bits for the 64-bit width. The masked count is then reduced modulo the operand width. A masked count of zero is a no-op for the flags. Any other masked count loads carry with the bit that wrapped around into bit 0. Overflow is recomputed only when the masked count is exactly one. In every other case the incoming overflow passes through, so the output stays deterministic.

A decode stage drives the inputs for one cycle with `in_valid` high. A writeback stage consumes the registered outputs when `out_valid` is high.

Top module: `rol_unit`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high and low otherwise. A synchronous active-high `rst` clears `out_valid` and `out_flag_we`.
- R2: The size code selects the operand width: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. Result bits at and above the selected width are zero, whatever the operand carries there.
- R3: The result is the low width bits of the operand rotated left by the effective count. Each bit leaving the top position re-enters at bit 0.
- R4: The count is masked with 0x1F for 8/16/32-bit widths and with 0x3F for the 64-bit width. It is then taken modulo the width. For example, a count of 27 on an 8-bit operand rotates by 3, and a count of 72 on a 64-bit operand rotates by 8.
- R5: A masked count of zero returns the operand's low width bits unchanged. Carry and overflow both keep their input values.
- R6: A nonzero masked count sets carry to bit 0 of the result. The incoming carry never enters the rotated value.
- R7: A masked count of exactly 1 sets overflow to the new carry XOR the result's top bit for the selected width.
- R8: For any masked count other than 1, overflow equals its input value.
- R9: `out_flag_we` is high exactly one cycle after a cycle where `in_valid` is high and the masked count is nonzero.
- R10: A masked count equal to the width (8 on an 8-bit operand, 16 on a 16-bit operand) leaves the value unchanged but still writes flags, with carry equal to bit 0. Counts of 32 on 32 bits and 64 on 64 bits mask to zero.
- R11: In a cycle with `in_valid` low, the result, carry and overflow outputs hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input operands present this cycle |
| in_operand | input | 64 | Value to rotate, low bits used per size |
| in_size | input | 2 | Width code: 0=8, 1=16, 2=32, 3=64 bits |
| in_count | input | 8 | Raw rotate count before masking |
| in_carry | input | 1 | Incoming carry flag |
| in_ovf | input | 1 | Incoming overflow flag |
| out_valid | output | 1 | Registered result present |
| out_result | output | 64 | Rotated value, zero above the width |
| out_carry | output | 1 | Updated carry flag |
| out_ovf | output | 1 | Updated overflow flag |
| out_flag_we | output | 1 | Flags are to be written back |

## Verification
Every output, including `out_valid` and `out_flag_we`, is due exactly one rising edge after the inputs are applied. The bench changes inputs on a falling edge and samples on the next falling edge, so exactly one register stage lies between stimulus and observation. The hold behaviour and the drop of `out_valid` are sampled one further falling edge later, after an idle cycle. The back-to-back test samples each result on the falling edge right after its own capture edge, while the next operand is already being driven.

// File: rtl/rol_pkg.sv
package rol_pkg;

    localparam int DATA_W  = 64;
    localparam int CNT_W   = 8;
    localparam int AMT_W   = $clog2(DATA_W);
    localparam int N_LANES = 4;
    localparam int MIN_W   = 8;

    typedef enum logic [1:0] {
        SZ_B8  = 2'd0,
        SZ_B16 = 2'd1,
        SZ_B32 = 2'd2,
        SZ_B64 = 2'd3
    } rol_size_e;

    typedef struct packed {
        logic [DATA_W-1:0] operand;
        rol_size_e         size;
        logic [CNT_W-1:0]  count;
        logic              carry;
        logic              ovf;
    } rol_req_t;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              carry;
        logic              ovf;
        logic              flag_we;
    } rol_rsp_t;

    typedef struct packed {
        logic [AMT_W-1:0] amt;
        logic             is_zero;
        logic             is_one;
    } rol_cnt_t;

    // Count mask: wider mask only for the full 64-bit width
    function automatic logic [CNT_W-1:0] count_mask(rol_size_e sz);
        return (sz == SZ_B64) ? CNT_W'(8'h3F) : CNT_W'(8'h1F);
    endfunction

    // Top bit of the result for the selected width
    function automatic logic top_bit(logic [DATA_W-1:0] v, rol_size_e sz);
        case (sz)
            SZ_B8:   return v[7];
            SZ_B16:  return v[15];
            SZ_B32:  return v[31];
            default: return v[63];
        endcase
    endfunction

endpackage

// File: rtl/rol_count_prep.sv
module rol_count_prep
    import rol_pkg::*;
(
    input  rol_size_e        size,
    input  logic [CNT_W-1:0] count,
    output rol_cnt_t         cnt
);

    logic [CNT_W-1:0] masked;

    always_comb begin
        masked      = count & count_mask(size);
        cnt.is_zero = (masked == '0);
        cnt.is_one  = (masked == CNT_W'(1));
        // modulo width: keep log2(width) low bits of the masked count
        case (size)
            SZ_B8:   cnt.amt = AMT_W'(masked[2:0]);
            SZ_B16:  cnt.amt = AMT_W'(masked[3:0]);
            SZ_B32:  cnt.amt = AMT_W'(masked[4:0]);
            default: cnt.amt = masked[AMT_W-1:0];
        endcase
    end

endmodule

// File: rtl/rol_lane.sv
module rol_lane #(
    parameter int W  = 8,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  din,
    input  logic [AW-1:0] amt,
    output logic [W-1:0]  dout
);

    logic [W-1:0] stage [0:AW];

    assign stage[0] = din;

    for (genvar s = 0; s < AW; s++) begin : g_stage
        localparam int SH = 1 << s;
        assign stage[s+1] = amt[s] ? {stage[s][W-1-SH:0], stage[s][W-1:W-SH]}
                                   : stage[s];
    end

    assign dout = stage[AW];

endmodule

// File: rtl/rol_barrel.sv
module rol_barrel
    import rol_pkg::*;
(
    input  logic [DATA_W-1:0] operand,
    input  rol_size_e         size,
    input  logic [AMT_W-1:0]  amt,
    output logic [DATA_W-1:0] result
);

    logic [DATA_W-1:0] lane_out [N_LANES];

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int LW  = MIN_W << g;
        localparam int LAW = $clog2(LW);
        logic [LW-1:0] rot;

        rol_lane #(.W(LW), .AW(LAW)) u_lane (
            .din  (operand[LW-1:0]),
            .amt  (amt[LAW-1:0]),
            .dout (rot)
        );

        assign lane_out[g] = DATA_W'(rot);
    end

    assign result = lane_out[size];

endmodule

// File: rtl/rol_flags.sv
module rol_flags
    import rol_pkg::*;
(
    input  logic [DATA_W-1:0] result,
    input  rol_size_e         size,
    input  rol_cnt_t          cnt,
    input  logic              carry_in,
    input  logic              ovf_in,
    output logic              carry_out,
    output logic              ovf_out,
    output logic              flag_we
);

    always_comb begin
        carry_out = cnt.is_zero ? carry_in : result[0];
        ovf_out   = cnt.is_one ? (result[0] ^ top_bit(result, size)) : ovf_in;
        flag_we   = !cnt.is_zero;
    end

endmodule

// File: rtl/rol_unit.sv
module rol_unit
    import rol_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [63:0] in_operand,
    input  logic [1:0]  in_size,
    input  logic [7:0]  in_count,
    input  logic        in_carry,
    input  logic        in_ovf,
    output logic        out_valid,
    output logic [63:0] out_result,
    output logic        out_carry,
    output logic        out_ovf,
    output logic        out_flag_we
);

    rol_req_t req;
    rol_cnt_t cnt;
    rol_rsp_t nxt;
    rol_rsp_t q;
    logic     valid_q;

    assign req.operand = in_operand;
    assign req.size    = rol_size_e'(in_size);
    assign req.count   = in_count;
    assign req.carry   = in_carry;
    assign req.ovf     = in_ovf;

    rol_count_prep u_prep (
        .size  (req.size),
        .count (req.count),
        .cnt   (cnt)
    );

    rol_barrel u_barrel (
        .operand (req.operand),
        .size    (req.size),
        .amt     (cnt.amt),
        .result  (nxt.result)
    );

    rol_flags u_flags (
        .result    (nxt.result),
        .size      (req.size),
        .cnt       (cnt),
        .carry_in  (req.carry),
        .ovf_in    (req.ovf),
        .carry_out (nxt.carry),
        .ovf_out   (nxt.ovf),
        .flag_we   (nxt.flag_we)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            q       <= '0;
        end else begin
            valid_q   <= in_valid;
            q.flag_we <= in_valid & nxt.flag_we;
            if (in_valid) begin
                q.result <= nxt.result;
                q.carry  <= nxt.carry;
                q.ovf    <= nxt.ovf;
            end
        end
    end

    assign out_valid   = valid_q;
    assign out_result  = q.result;
    assign out_carry   = q.carry;
    assign out_ovf     = q.ovf;
    assign out_flag_we = q.flag_we;

endmodule

// File: rtl/rol_unit_chk.sv
module rol_unit_chk
    import rol_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [63:0] in_operand,
    input logic [1:0]  in_size,
    input logic [7:0]  in_count,
    input logic        in_carry,
    input logic        in_ovf,
    input logic        out_valid,
    input logic [63:0] out_result,
    input logic        out_carry,
    input logic        out_ovf,
    input logic        out_flag_we
);

    logic unused_ok;
    assign unused_ok = ^in_operand;

    // R1: valid follows valid-in by one cycle
    a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    a_r1_idle_follows: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R2: nothing above an 8-bit width
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(in_size) == 2'd0 |-> out_result[63:8] == '0);

    // R5: without a flag write both flags pass through
    a_r5_flags_kept: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_flag_we |-> out_carry == $past(in_carry) && out_ovf == $past(in_ovf));

    // R6: a flag write puts the wrapped bit into carry
    a_r6_carry_lsb: assert property (@(posedge clk) disable iff (rst)
        out_flag_we |-> out_carry == out_result[0]);

    // R7: single-bit rotate overflow
    a_r7_ovf_one: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(in_count) == 8'd1 |->
        out_ovf == (out_carry ^ top_bit(out_result, rol_size_e'($past(in_size)))));

    // R8: count of two keeps overflow
    a_r8_ovf_pass: assert property (@(posedge clk) disable iff (rst)
        out_valid && $past(in_count) == 8'd2 |-> out_ovf == $past(in_ovf));

    // R9: flag write only with a valid result
    a_r9_we_valid: assert property (@(posedge clk) disable iff (rst)
        out_flag_we |-> out_valid);

endmodule

bind rol_unit rol_unit_chk u_chk (.*);

// File: tb/rol_unit_test.sv
`timescale 1ns/1ps
module rol_unit_test;

    typedef struct packed {
        logic [1:0]  sz;
        logic [7:0]  cnt;
        logic [63:0] op;
        logic        cin;
        logic        oin;
        logic [63:0] res;
        logic        cout;
        logic        oout;
        logic        we;
    } vec_t;

    localparam int NV = 26;
    // fields: size, count, operand, carry-in, ovf-in, result, carry, ovf, flag-write
    localparam vec_t VECS [NV] = '{
        '{2'd0, 8'd1,   64'h42, 1'b1, 1'b0, 64'h84, 1'b0, 1'b1, 1'b1},             // R3 R7
        '{2'd0, 8'd1,   64'h81, 1'b0, 1'b0, 64'h03, 1'b1, 1'b1, 1'b1},             // R3 R6
        '{2'd0, 8'd4,   64'h01, 1'b1, 1'b1, 64'h10, 1'b0, 1'b1, 1'b1},             // R8
        '{2'd0, 8'd27,  64'h11, 1'b1, 1'b0, 64'h88, 1'b0, 1'b0, 1'b1},             // R4
        '{2'd0, 8'd8,   64'h43, 1'b0, 1'b1, 64'h43, 1'b1, 1'b1, 1'b1},             // R10
        '{2'd0, 8'd0,   64'h42, 1'b1, 1'b1, 64'h42, 1'b1, 1'b1, 1'b0},             // R5
        '{2'd0, 8'd32,  64'h5A, 1'b0, 1'b1, 64'h5A, 1'b0, 1'b1, 1'b0},             // R4 R5
        '{2'd0, 8'd1,   64'hFFFFFFFFFFFFFFC5, 1'b0, 1'b0, 64'h8B, 1'b1, 1'b0, 1'b1}, // R2
        '{2'd1, 8'd1,   64'h4321, 1'b0, 1'b0, 64'h8642, 1'b0, 1'b1, 1'b1},         // R7
        '{2'd1, 8'd4,   64'h1234, 1'b0, 1'b0, 64'h2341, 1'b1, 1'b0, 1'b1},         // R6
        '{2'd1, 8'd8,   64'h1234, 1'b0, 1'b1, 64'h3412, 1'b0, 1'b1, 1'b1},         // R3
        '{2'd1, 8'd16,  64'hABCD, 1'b0, 1'b0, 64'hABCD, 1'b1, 1'b0, 1'b1},         // R10
        '{2'd1, 8'd1,   64'h8000, 1'b0, 1'b0, 64'h0001, 1'b1, 1'b1, 1'b1},         // R7
        '{2'd2, 8'd8,   64'h12345678, 1'b1, 1'b1, 64'h34567812, 1'b0, 1'b1, 1'b1}, // R3
        '{2'd2, 8'd32,  64'h12345678, 1'b1, 1'b0, 64'h12345678, 1'b1, 1'b0, 1'b0}, // R10
        '{2'd2, 8'd24,  64'hFF, 1'b1, 1'b0, 64'hFF000000, 1'b0, 1'b0, 1'b1},       // R3
        '{2'd2, 8'd12,  64'h12345678, 1'b0, 1'b0, 64'h45678123, 1'b1, 1'b0, 1'b1}, // R6
        '{2'd2, 8'd1,   64'h40000000, 1'b0, 1'b0, 64'h80000000, 1'b0, 1'b1, 1'b1}, // R7
        '{2'd2, 8'd1,   64'hDEADBEEF80000000, 1'b0, 1'b0, 64'h1, 1'b1, 1'b1, 1'b1}, // R2
        '{2'd3, 8'd1,   64'h4321876543218765, 1'b1, 1'b0, 64'h86430ECA86430ECA, 1'b0, 1'b1, 1'b1}, // R7
        '{2'd3, 8'd32,  64'h123456789ABCDEF0, 1'b0, 1'b1, 64'h9ABCDEF012345678, 1'b0, 1'b1, 1'b1}, // R3
        '{2'd3, 8'd64,  64'h123456789ABCDEF0, 1'b1, 1'b1, 64'h123456789ABCDEF0, 1'b1, 1'b1, 1'b0}, // R10
        '{2'd3, 8'd1,   64'hFEDCBA9876543210, 1'b0, 1'b1, 64'hFDB97530ECA86421, 1'b1, 1'b0, 1'b1}, // R6
        '{2'd3, 8'd72,  64'h123456789ABCDEF0, 1'b1, 1'b0, 64'h3456789ABCDEF012, 1'b0, 1'b0, 1'b1}, // R4
        '{2'd3, 8'd56,  64'hFF, 1'b1, 1'b1, 64'hFF00000000000000, 1'b0, 1'b1, 1'b1}, // R3
        '{2'd0, 8'hE1,  64'h42, 1'b1, 1'b0, 64'h84, 1'b0, 1'b1, 1'b1}              // R4 R7
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] in_operand = '0;
    logic [1:0]  in_size = '0;
    logic [7:0]  in_count = '0;
    logic        in_carry = 1'b0;
    logic        in_ovf = 1'b0;
    logic        out_valid;
    logic [63:0] out_result;
    logic        out_carry;
    logic        out_ovf;
    logic        out_flag_we;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    rol_unit uut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_operand  (in_operand),
        .in_size     (in_size),
        .in_count    (in_count),
        .in_carry    (in_carry),
        .in_ovf      (in_ovf),
        .out_valid   (out_valid),
        .out_result  (out_result),
        .out_carry   (out_carry),
        .out_ovf     (out_ovf),
        .out_flag_we (out_flag_we)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(vec_t v);
        in_valid   = 1'b1;
        in_size    = v.sz;
        in_count   = v.cnt;
        in_operand = v.op;
        in_carry   = v.cin;
        in_ovf     = v.oin;
    endtask

    task automatic check_vec(vec_t v, int idx);
        check($sformatf("R1 valid vec%0d", idx), 64'(out_valid), 64'd1);
        check($sformatf("R3 result vec%0d", idx), out_result, v.res);
        check($sformatf("R6 carry vec%0d", idx), 64'(out_carry), 64'(v.cout));
        check($sformatf("R7 ovf vec%0d", idx), 64'(out_ovf), 64'(v.oout));
        check($sformatf("R9 flag_we vec%0d", idx), 64'(out_flag_we), 64'(v.we));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 R9: reset state
        repeat (3) @(negedge clk);
        check("R1 reset valid", 64'(out_valid), 64'd0);
        check("R9 reset flag_we", 64'(out_flag_we), 64'd0);
        rst = 1'b0;

        // table walk, one idle cycle between vectors
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            @(negedge clk);
            check_vec(VECS[i], i);
            in_valid = 1'b0;
        end

        // R11 hold: idle cycle with changed inputs keeps outputs
        @(negedge clk);
        drive(VECS[0]);
        @(negedge clk);
        check_vec(VECS[0], 100);
        in_valid   = 1'b0;
        in_operand = 64'hFF;
        in_count   = 8'd3;
        in_carry   = 1'b1;
        in_ovf     = 1'b0;
        @(negedge clk);
        check("R1 idle valid", 64'(out_valid), 64'd0);
        check("R9 idle flag_we", 64'(out_flag_we), 64'd0);
        check("R11 hold result", out_result, 64'h84);
        check("R11 hold carry", 64'(out_carry), 64'd0);
        check("R11 hold ovf", 64'(out_ovf), 64'd1);

        // R1 back-to-back issue
        @(negedge clk);
        drive(VECS[9]);
        @(negedge clk);
        check_vec(VECS[9], 101);
        drive(VECS[20]);
        @(negedge clk);
        check_vec(VECS[20], 102);
        drive(VECS[3]);
        @(negedge clk);
        check_vec(VECS[3], 103);

        // R1 reset while valid is high
        drive(VECS[1]);
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset clears valid", 64'(out_valid), 64'd0);
        check("R9 reset clears flag_we", 64'(out_flag_we), 64'd0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule